// File: doc/BRIEF.md
# Power Domain State Controller

This block walks a single power domain between its run and low-power states and drives the switch and supply controls for that domain. Software writes a target state, the memory-array options and a settle count in one cycle. From then on the block sequences the change by itself. It gates the domain clocks, moves the logic power switch and the logic supply level, handles the array switch and the array supply request, and holds and releases the reset of the non-retention flops.

Five states are supported: On, clock-gated Inactive, closed-switch retention, open-switch retention and Off. The deeper states come first in the encoding, so a lower code means a lower-power state. A move to a lower-power state gates the clocks for one cycle before any supply control changes. A move to a higher-power state closes the logic switch at nominal supply first. It then waits the programmed number of settle cycles and releases the non-retention reset. Only after that are the clocks re-enabled. A parameter states whether the domain has retention flops. A domain without them never enters open-switch retention. Other parameters can hardwire the array switch and the array supply level.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: After reset the domain is On: pwr_on=1, vdd_ret=0, clk_en=1, nret_rst=0, stat_busy=0, stat_state=4, array_on=1 (unless hardwired), array_low=0 (unless hardwired).
- R2: State codes are 0 Off, 1 open-switch retention, 2 closed-switch retention, 3 Inactive and 4 On. Codes 5 to 7 resolve to closed-switch retention. Code 1 also resolves to closed-switch retention when HAS_RFF is 0, so stat_state never reads 1 in such a domain.
- R3: In a settled state, pwr_on is 1 for codes 2..4 and 0 for codes 0..1. vdd_ret is 1 for codes 1..2 and 0 otherwise. clk_en is 1 only for code 4. nret_rst is 1 for codes 0..1 and 0 otherwise.
- R4: On a request for a lower code, there is exactly one busy cycle with clk_en=0 while pwr_on and vdd_ret keep the old state's values. The new state's values appear in the following cycle.
- R5: On a request for a higher code, the first busy cycle has pwr_on=1, vdd_ret=0 and clk_en=0, with nret_rst as in the old state. Then come exactly N settle cycles (N = settle_cycles sampled at acceptance, 0 allowed) with the same outputs. Then one cycle with nret_rst=0 and clk_en=0. Then the target state.
- R6: array_on and array_low take the software options from the cycle after the request is accepted. With ARRAY_FIXED=1 they take ARRAY_FIX_ON and ARRAY_FIX_LOW instead. array_on is forced to 0 whenever the settled state is Off.
- R7: stat_state reports the current state in the R2 encoding and changes on the cycle the transition completes.
- R8: stat_busy is 1 exactly while a transition is in progress. A request arriving while busy is held and is started on the first idle cycle. If several arrive, the last one wins.
- R9: A request for the state already in force starts no transition: stat_busy stays 0 and only the array options are updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Software write strobe for a new target |
| req_state | input | 3 | Target state code |
| req_arr_on | input | 1 | Software option: keep array switch closed |
| req_arr_low | input | 1 | Software option: request lowered array supply |
| settle_cycles | input | SETTLE_W | Settle cycles between switch closing and reset release |
| pwr_on | output | 1 | Logic power-on switch control |
| vdd_ret | output | 1 | Logic supply at retention level when 1, nominal when 0 |
| array_on | output | 1 | Array switch control |
| array_low | output | 1 | Array supply request: lowered when 1 |
| clk_en | output | 1 | Domain clock enable |
| nret_rst | output | 1 | Reset for non-retention flops, active high |
| stat_state | output | 3 | Current state code |
| stat_busy | output | 1 | Transition in progress |

## Verification
The assertions assume that settle_cycles is stable only where it matters, which is the cycle a request is accepted. They assume no request code other than a 3-bit value is ever seen, and that reset reaches the core only through the internal synchroniser. The stimulus drives every input half a cycle away from the active edge. It holds req_valid for one cycle per write, fires requests both while idle and in the middle of a wake or settle sequence, and sweeps settle counts from zero to small values. This keeps every window short enough to cover within the run.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [2:0] {
    PD_OFF   = 3'd0,
    PD_OSWR  = 3'd1,
    PD_CSWR  = 3'd2,
    PD_INACT = 3'd3,
    PD_ON    = 3'd4
  } pd_state_e;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_GATE    = 3'd1,
    PH_WAKE    = 3'd2,
    PH_SETTLE  = 3'd3,
    PH_RELEASE = 3'd4
  } pd_phase_e;

  typedef struct packed {
    pd_state_e state;
    logic      arr_on;
    logic      arr_low;
  } pd_req_t;

  // Map a raw code onto a state the domain can actually reach.
  function automatic pd_state_e pd_legal(input logic [2:0] code, input bit has_rff);
    if (code > 3'd4)                 return PD_CSWR;
    if (code == 3'd1 && !has_rff)    return PD_CSWR;
    return pd_state_e'(code);
  endfunction

endpackage

// File: rtl/pdc_req.sv
module pdc_req
  import pdc_pkg::*;
#(
  parameter bit HAS_RFF = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle,
  input  logic       req_valid,
  input  logic [2:0] req_state,
  input  logic       req_arr_on,
  input  logic       req_arr_low,
  output logic       sel_valid,
  output pd_req_t    sel
);

  pd_req_t live;
  pd_req_t hold_q;
  logic    hold_en;
  logic    pend_q, pend_d;

  always_comb begin
    live.state   = pd_legal(req_state, HAS_RFF);
    live.arr_on  = req_arr_on;
    live.arr_low = req_arr_low;
  end

  // Capture while busy; the sequencer consumes the selection when idle.
  always_comb begin
    hold_en = req_valid & ~idle;
    pend_d  = idle ? 1'b0 : (pend_q | req_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= '{state: PD_ON, arr_on: 1'b1, arr_low: 1'b0};
    end else begin
      pend_q <= pend_d;
      if (hold_en) hold_q <= live;
    end
  end

  always_comb begin
    sel_valid = req_valid | pend_q;
    sel       = req_valid ? live : hold_q;
  end

  assert_pend_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !idle) |=> pend_q)
    else $error("held request dropped while busy");

  assert_pend_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && idle) |=> !pend_q || !$past(idle) )
    else $error("held request not consumed on idle");

endmodule

// File: rtl/pdc_seq.sv
module pdc_seq
  import pdc_pkg::*;
#(
  parameter int unsigned SETTLE_W = 8,
  parameter bit          HAS_RFF  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_valid,
  input  pd_req_t             sel,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output pd_phase_e           phase,
  output pd_state_e           cur,
  output logic                opt_on,
  output logic                opt_low,
  output logic                idle
);

  localparam logic [SETTLE_W-1:0] CNT_ONE = SETTLE_W'(1);

  pd_phase_e           phase_q, phase_d;
  pd_state_e           cur_q, cur_d;
  pd_state_e           tgt_q, tgt_d;
  logic [SETTLE_W-1:0] cnt_q, cnt_d;
  logic                opt_on_q, opt_low_q;
  logic                opt_en;

  always_comb begin
    phase_d = phase_q;
    cur_d   = cur_q;
    tgt_d   = tgt_q;
    cnt_d   = cnt_q;
    opt_en  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (sel_valid) begin
          opt_en = 1'b1;
          tgt_d  = sel.state;
          if (sel.state < cur_q) begin
            phase_d = PH_GATE;
          end else if (sel.state > cur_q) begin
            phase_d = PH_WAKE;
            cnt_d   = settle_cycles;
          end
        end
      end
      PH_GATE: begin
        phase_d = PH_IDLE;
        cur_d   = tgt_q;
      end
      PH_WAKE: begin
        phase_d = (cnt_q == '0) ? PH_RELEASE : PH_SETTLE;
      end
      PH_SETTLE: begin
        if (cnt_q == CNT_ONE) phase_d = PH_RELEASE;
        else                  cnt_d   = cnt_q - CNT_ONE;
      end
      PH_RELEASE: begin
        phase_d = PH_IDLE;
        cur_d   = tgt_q;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cur_q     <= PD_ON;
      tgt_q     <= PD_ON;
      cnt_q     <= '0;
      opt_on_q  <= 1'b1;
      opt_low_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cur_q   <= cur_d;
      tgt_q   <= tgt_d;
      cnt_q   <= cnt_d;
      if (opt_en) begin
        opt_on_q  <= sel.arr_on;
        opt_low_q <= sel.arr_low;
      end
    end
  end

  always_comb begin
    phase   = phase_q;
    cur     = cur_q;
    opt_on  = opt_on_q;
    opt_low = opt_low_q;
    idle    = (phase_q == PH_IDLE);
  end

  assert_settle_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETTLE) |-> (cnt_q != '0))
    else $error("settle counter underflow");

  assert_gate_completes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_GATE) |=> (phase_q == PH_IDLE && cur_q == $past(tgt_q)))
    else $error("gate phase did not commit target");

  assert_same_state_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && sel_valid && sel.state == cur_q) |=> (phase_q == PH_IDLE))
    else $error("same-state request started a transition");

  generate
    if (!HAS_RFF) begin : g_no_rff_chk
      assert_no_oswr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q != PD_OSWR)
        else $error("open-switch retention reached without retention flops");
    end
  endgenerate

endmodule

// File: rtl/pdc_out.sv
module pdc_out
  import pdc_pkg::*;
#(
  parameter bit ARRAY_FIXED   = 1'b0,
  parameter bit ARRAY_FIX_ON  = 1'b1,
  parameter bit ARRAY_FIX_LOW = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  pd_phase_e phase,
  input  pd_state_e cur,
  input  logic      opt_on,
  input  logic      opt_low,
  output logic      pwr_on,
  output logic      vdd_ret,
  output logic      array_on,
  output logic      array_low,
  output logic      clk_en,
  output logic      nret_rst,
  output logic      busy
);

  logic src_on, src_low;
  logic st_pwr, st_ret, st_clk, st_nret;

  generate
    if (ARRAY_FIXED) begin : g_arr_fixed
      logic unused_opts;
      assign unused_opts = opt_on ^ opt_low;
      assign src_on  = ARRAY_FIX_ON;
      assign src_low = ARRAY_FIX_LOW;
    end else begin : g_arr_sw
      assign src_on  = opt_on;
      assign src_low = opt_low;
    end
  endgenerate

  // Settled-state supply table.
  always_comb begin
    st_pwr  = (cur >= PD_CSWR);
    st_ret  = (cur == PD_OSWR) || (cur == PD_CSWR);
    st_clk  = (cur == PD_ON);
    st_nret = (cur <= PD_OSWR);
  end

  always_comb begin
    pwr_on   = 1'b1;
    vdd_ret  = 1'b0;
    clk_en   = 1'b0;
    nret_rst = st_nret;
    case (phase)
      PH_IDLE: begin
        pwr_on  = st_pwr;
        vdd_ret = st_ret;
        clk_en  = st_clk;
      end
      PH_GATE: begin
        pwr_on  = st_pwr;
        vdd_ret = st_ret;
      end
      PH_RELEASE: nret_rst = 1'b0;
      default: ;
    endcase
    array_on  = src_on & ~(phase == PH_IDLE && cur == PD_OFF);
    array_low = src_low;
    busy      = (phase != PH_IDLE);
  end

  assert_busy_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !clk_en)
    else $error("clock enabled during a transition");

  assert_supply_after_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwr_on) || $rose(vdd_ret)) |-> !$past(clk_en))
    else $error("supply moved while clocks were running");

  assert_nret_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nret_rst) |-> (pwr_on && !vdd_ret && !clk_en))
    else $error("non-retention reset released without nominal supply");

  assert_clk_after_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> (!nret_rst && $past(!nret_rst)))
    else $error("clocks enabled before reset release");

endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl
  import pdc_pkg::*;
#(
  parameter int unsigned SETTLE_W      = 8,
  parameter bit          HAS_RFF       = 1'b1,
  parameter bit          ARRAY_FIXED   = 1'b0,
  parameter bit          ARRAY_FIX_ON  = 1'b1,
  parameter bit          ARRAY_FIX_LOW = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [2:0]          req_state,
  input  logic                req_arr_on,
  input  logic                req_arr_low,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                pwr_on,
  output logic                vdd_ret,
  output logic                array_on,
  output logic                array_low,
  output logic                clk_en,
  output logic                nret_rst,
  output logic [2:0]          stat_state,
  output logic                stat_busy
);

  logic      rst_s1, core_rst_n;
  logic      idle, sel_valid, opt_on, opt_low;
  pd_req_t   sel;
  pd_phase_e phase;
  pd_state_e cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      core_rst_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      core_rst_n <= rst_s1;
    end
  end

  pdc_req #(.HAS_RFF(HAS_RFF)) u_req (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .idle        (idle),
    .req_valid   (req_valid),
    .req_state   (req_state),
    .req_arr_on  (req_arr_on),
    .req_arr_low (req_arr_low),
    .sel_valid   (sel_valid),
    .sel         (sel)
  );

  pdc_seq #(.SETTLE_W(SETTLE_W), .HAS_RFF(HAS_RFF)) u_seq (
    .clk           (clk),
    .rst_n         (core_rst_n),
    .sel_valid     (sel_valid),
    .sel           (sel),
    .settle_cycles (settle_cycles),
    .phase         (phase),
    .cur           (cur),
    .opt_on        (opt_on),
    .opt_low       (opt_low),
    .idle          (idle)
  );

  pdc_out #(
    .ARRAY_FIXED   (ARRAY_FIXED),
    .ARRAY_FIX_ON  (ARRAY_FIX_ON),
    .ARRAY_FIX_LOW (ARRAY_FIX_LOW)
  ) u_out (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .phase     (phase),
    .cur       (cur),
    .opt_on    (opt_on),
    .opt_low   (opt_low),
    .pwr_on    (pwr_on),
    .vdd_ret   (vdd_ret),
    .array_on  (array_on),
    .array_low (array_low),
    .clk_en    (clk_en),
    .nret_rst  (nret_rst),
    .busy      (stat_busy)
  );

  assign stat_state = cur;

  assert_off_array_open_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!stat_busy && stat_state == 3'd0) |-> !array_on)
    else $error("array switch closed in Off");

  assert_status_stable_idle_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    ($past(!stat_busy) && !stat_busy) |-> $stable(stat_state))
    else $error("status changed without a transition");

endmodule

// File: tb/tb_pwr_domain_ctrl.sv
module tb_pwr_domain_ctrl;

  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [2:0]    req_state = 3'd0;
  logic          req_arr_on = 1'b0;
  logic          req_arr_low = 1'b0;
  logic [SW-1:0] settle_cycles = '0;

  logic       o_pwr[2], o_ret[2], o_aon[2], o_alow[2], o_clk[2], o_nret[2], o_busy[2];
  logic [2:0] o_stat[2];

  pwr_domain_ctrl #(.SETTLE_W(SW), .HAS_RFF(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_state(req_state),
    .req_arr_on(req_arr_on), .req_arr_low(req_arr_low), .settle_cycles(settle_cycles),
    .pwr_on(o_pwr[0]), .vdd_ret(o_ret[0]), .array_on(o_aon[0]), .array_low(o_alow[0]),
    .clk_en(o_clk[0]), .nret_rst(o_nret[0]), .stat_state(o_stat[0]), .stat_busy(o_busy[0]));

  pwr_domain_ctrl #(.SETTLE_W(SW), .HAS_RFF(1'b0), .ARRAY_FIXED(1'b1),
                    .ARRAY_FIX_ON(1'b1), .ARRAY_FIX_LOW(1'b1)) dut_norff (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_state(req_state),
    .req_arr_on(req_arr_on), .req_arr_low(req_arr_low), .settle_cycles(settle_cycles),
    .pwr_on(o_pwr[1]), .vdd_ret(o_ret[1]), .array_on(o_aon[1]), .array_low(o_alow[1]),
    .clk_en(o_clk[1]), .nret_rst(o_nret[1]), .stat_state(o_stat[1]), .stat_busy(o_busy[1]));

  int checks = 0;
  int fails  = 0;
  bit run    = 1'b0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model: phase 0 idle, 1 gate, 2 wake, 3 settle, 4 release.
  int m_has[2]  = '{1, 0};
  int m_fix[2]  = '{0, 1};
  int m_ph[2]   = '{0, 0};
  int m_cur[2]  = '{4, 4};
  int m_tgt[2]  = '{4, 4};
  int m_cnt[2]  = '{0, 0};
  int m_on[2]   = '{1, 1};
  int m_low[2]  = '{0, 0};
  int m_pv[2]   = '{0, 0};
  int m_ps[2]   = '{0, 0};
  int m_pon[2]  = '{0, 0};
  int m_plow[2] = '{0, 0};
  int m_sync    = 0;

  function automatic int legal(input int code, input int has);
    if (code > 4) return 2;
    if (code == 1 && has == 0) return 2;
    return code;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 2; i++) begin
      m_ph[i] = 0; m_cur[i] = 4; m_tgt[i] = 4; m_cnt[i] = 0;
      m_on[i] = 1; m_low[i] = 0; m_pv[i] = 0;
    end
  endtask

  task automatic m_step(input int i);
    int s, on, lo;
    if (m_ph[i] == 0) begin
      if (req_valid || m_pv[i] != 0) begin
        if (req_valid) begin
          s = legal(int'(req_state), m_has[i]); on = int'(req_arr_on); lo = int'(req_arr_low);
        end else begin
          s = m_ps[i]; on = m_pon[i]; lo = m_plow[i];
        end
        m_pv[i] = 0; m_on[i] = on; m_low[i] = lo; m_tgt[i] = s;
        if (s < m_cur[i]) m_ph[i] = 1;
        else if (s > m_cur[i]) begin m_ph[i] = 2; m_cnt[i] = int'(settle_cycles); end
      end
    end else begin
      if (req_valid) begin
        m_pv[i] = 1; m_ps[i] = legal(int'(req_state), m_has[i]);
        m_pon[i] = int'(req_arr_on); m_plow[i] = int'(req_arr_low);
      end
      case (m_ph[i])
        1: begin m_ph[i] = 0; m_cur[i] = m_tgt[i]; end
        2: m_ph[i] = (m_cnt[i] == 0) ? 4 : 3;
        3: if (m_cnt[i] == 1) m_ph[i] = 4; else m_cnt[i]--;
        4: begin m_ph[i] = 0; m_cur[i] = m_tgt[i]; end
        default: m_ph[i] = 0;
      endcase
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_reset();
    end else if (m_sync < 2) begin
      m_sync++; m_reset();
    end else begin
      for (int i = 0; i < 2; i++) m_step(i);
    end
  end

  // Compare every output of both instances on every falling edge.
  always @(negedge clk) begin
    if (run) begin
      for (int i = 0; i < 2; i++) begin
        int ph, cu, e_pwr, e_ret, e_clk, e_nret, e_aon, e_alow;
        ph = m_ph[i]; cu = m_cur[i];
        e_pwr  = (ph <= 1) ? int'(cu >= 2) : 1;
        e_ret  = (ph <= 1) ? int'(cu == 1 || cu == 2) : 0;
        e_clk  = int'(ph == 0 && cu == 4);
        e_nret = (ph == 4) ? 0 : int'(cu <= 1);
        e_aon  = ((m_fix[i] != 0) ? 1 : m_on[i]) & int'(!(ph == 0 && cu == 0));
        e_alow = (m_fix[i] != 0) ? 1 : m_low[i];
        check("R3", "pwr_on",   int'(o_pwr[i]),  e_pwr);
        check("R3", "vdd_ret",  int'(o_ret[i]),  e_ret);
        check("R4", "clk_en",   int'(o_clk[i]),  e_clk);
        check("R5", "nret_rst", int'(o_nret[i]), e_nret);
        check("R6", "array_on", int'(o_aon[i]),  e_aon);
        check("R6", "array_low",int'(o_alow[i]), e_alow);
        check("R7", "stat",     int'(o_stat[i]), cu);
        check("R8", "busy",     int'(o_busy[i]), int'(ph != 0));
      end
    end
  end

  // Drive one request for one cycle; returns on the falling edge after acceptance.
  task automatic send(input int st, input int on, input int lo, input int settle);
    @(negedge clk);
    req_valid = 1'b1; req_state = 3'(st); req_arr_on = 1'(on);
    req_arr_low = 1'(lo); settle_cycles = SW'(settle);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 64; k++) begin
      if (!o_busy[0] && !o_busy[1]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    run = 1'b1;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1", "stat",   int'(o_stat[0]), 4);
    check("R1", "clk_en", int'(o_clk[0]),  1);
    check("R1", "busy",   int'(o_busy[0]), 0);
    check("R1", "aon",    int'(o_aon[0]),  1);
    check("R1", "nret",   int'(o_nret[0]), 0);

    // R4 On -> Inactive: one gate cycle with old supplies
    send(3, 1, 0, 3);
    check("R4", "gate clk_en", int'(o_clk[0]), 0);
    check("R4", "gate pwr_on", int'(o_pwr[0]), 1);
    check("R8", "gate busy",   int'(o_busy[0]), 1);
    @(negedge clk);
    check("R7", "stat inactive", int'(o_stat[0]), 3);

    // R3 closed-switch retention
    send(2, 1, 1, 3);
    @(negedge clk);
    check("R3", "cswr vdd_ret", int'(o_ret[0]), 1);
    check("R6", "cswr array_low", int'(o_alow[0]), 1);

    // R2 open-switch retention; no-RFF instance stays put
    send(1, 1, 1, 3);
    check("R2", "norff not busy", int'(o_busy[1]), 0);
    @(negedge clk);
    check("R3", "oswr pwr_on", int'(o_pwr[0]), 0);
    check("R3", "oswr nret",   int'(o_nret[0]), 1);
    check("R2", "norff stat",  int'(o_stat[1]), 2);

    // R5 wake to On with settle 3
    send(4, 1, 0, 3);
    check("R5", "wake pwr_on", int'(o_pwr[0]), 1);
    check("R5", "wake nret",   int'(o_nret[0]), 1);
    repeat (3) @(negedge clk);
    check("R5", "settle nret", int'(o_nret[0]), 1);
    @(negedge clk);
    check("R5", "release nret", int'(o_nret[0]), 0);
    check("R5", "release clk",  int'(o_clk[0]), 0);
    @(negedge clk);
    check("R5", "on clk_en", int'(o_clk[0]), 1);

    // R6 Off forces array open on both instances
    send(0, 1, 0, 2);
    @(negedge clk);
    check("R6", "off aon",       int'(o_aon[0]), 0);
    check("R6", "off aon fixed", int'(o_aon[1]), 0);

    // R2 reserved code, settle 0
    send(6, 0, 0, 0);
    repeat (2) @(negedge clk);
    check("R2", "reserved -> cswr", int'(o_stat[0]), 2);
    check("R6", "sw aon 0",    int'(o_aon[0]), 0);
    check("R6", "fixed aon 1", int'(o_aon[1]), 1);

    // R9 same-state request only updates options
    send(2, 1, 0, 0);
    check("R9", "no busy", int'(o_busy[0]), 0);
    check("R9", "aon updated", int'(o_aon[0]), 1);

    // R8 requests during a transition, last one wins
    send(4, 1, 0, 4);
    req_valid = 1'b1; req_state = 3'd3;
    @(negedge clk);
    req_state = 3'd0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    check("R8", "last pending wins", int'(o_stat[0]), 0);
    check("R8", "last pending wins norff", int'(o_stat[1]), 0);

    // Mixed traffic, compared against the model every cycle
    for (int n = 0; n < 400; n++) begin
      send(int'($urandom_range(0, 7)), int'($urandom_range(0, 1)),
           int'($urandom_range(0, 1)), int'($urandom_range(0, 4)));
      repeat (int'($urandom_range(0, 12))) @(negedge clk);
    end
    wait_idle();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule